// File: doc/BRIEF.md
# Programmable Line Glitch Filter

This block cleans up the raw level of an asynchronous single-wire bus, such as a consumer-electronics control line, before a protocol decoder sees it. The line is first brought into the system clock domain by a two-flop synchroniser. A prescaler chain produces a periodic sampling tick from one of four time bases. A new level is accepted only after it has been held for three times the programmed delay, counted in ticks. Any pulse shorter than that is dropped.

A delay of zero, or a cleared enable, turns the filter into a plain synchroniser. Every change of the cleaned level comes with a one-cycle rise or fall pulse, so the decoder downstream can measure bit timing without a second edge detector. With the usual setting (1 µs tick, delay 7), the filter rejects any excursion shorter than about 21 µs.

Top module: `line_deglitch`

## Requirements
- R1: While rst_ni is low and after its release, line_o is 1 (the bus idle level) and rise_o and fall_o are 0.
- R2: With filt_en_i high and delay_i equal to 0, line_o takes each level of line_i exactly 3 clock cycles later: two synchroniser flops, then the output register. A pulse lasting a single cycle is passed through.
- R3: With filt_en_i low, line_o follows line_i with the 3-cycle latency of R2, whatever the value of delay_i.
- R4: tick_sel_i picks the tick period: 0 is XTAL_DIV cycles, 1 is US_CYCLES cycles, 2 is US_CYCLES*DECADE cycles and 3 is US_CYCLES*DECADE*DECADE cycles.
- R5: With filtering active, define N = 3*delay_i and P = the tick period. A change of line_i that lasts at most (N-1)*P - 1 cycles leaves line_o unchanged. This holds for low pulses while line_o is high and for high pulses while line_o is low.
- R6: With filtering active, a level that is held long enough appears on line_o between (N-1)*P+3 and N*P+2 cycles after line_i changes.
- R7: If line_i returns to the level of line_o for even one cycle, the qualification count restarts. Two sub-threshold pulses separated by a one-cycle gap are therefore both rejected.
- R8: rise_o is high for exactly one cycle, the first cycle in which line_o is 1 after being 0. fall_o behaves the same way for a change from 1 to 0. Neither pulses when line_o does not change, and they are never high together.
- R9: With filtering active, line_o changes only in the cycle after a tick, and only to the synchronised input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Raw asynchronous bus level |
| tick_sel_i | input | 2 | Time base: 0 crystal/3, 1 = 1 µs, 2 = 10 µs, 3 = 100 µs |
| delay_i | input | 3 | Delay factor; rejection width is delay × tick × 3 |
| filt_en_i | input | 1 | 1 = filter active, 0 = synchroniser only |
| line_o | output | 1 | Filtered line level |
| rise_o | output | 1 | One-cycle pulse when line_o goes high |
| fall_o | output | 1 | One-cycle pulse when line_o goes low |

## Verification
The two events that can land in the same cycle are a tick that would advance the qualification count and the input returning to the accepted level, which clears the count. The bench provokes this with pulses exactly one tick short of the threshold and with a one-cycle return between two such pulses. Clearing must win, and the bench judges this by seeing no fall or rise pulse and line_o unchanged after the line settles. The same tick must also never move line_o while the input equals it, and the checker enforces this.

// File: rtl/lg_pkg.sv
package lg_pkg;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned DEL_W  = 3;
  localparam int unsigned DEL_MULT = 3;
  localparam int unsigned NUM_BASES = 2 ** SEL_W;
  // bases above the 1us tick, each one decade slower
  localparam int unsigned NUM_DEC = NUM_BASES - 2;

  typedef enum logic [SEL_W-1:0] {
    TB_XTAL  = 2'd0,
    TB_1US   = 2'd1,
    TB_10US  = 2'd2,
    TB_100US = 2'd3
  } tick_base_e;
endpackage

// File: rtl/lg_sync.sv
module lg_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lg_tick_gen.sv
module lg_tick_gen
  import lg_pkg::*;
#(
  parameter int unsigned XTAL_DIV  = 3,
  parameter int unsigned US_CYCLES = 24,
  parameter int unsigned DECADE    = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  tick_base_e sel_i,
  output logic       tick_o
);
  localparam int unsigned XW = $clog2(XTAL_DIV + 1);
  localparam int unsigned UW = $clog2(US_CYCLES + 1);
  localparam int unsigned DW = $clog2(DECADE + 1);

  logic [XW-1:0] xtal_cnt_q;
  logic [UW-1:0] us_cnt_q;
  logic          xtal_tick;
  logic [NUM_DEC:0] stage_tick;

  assign xtal_tick     = (xtal_cnt_q == XW'(XTAL_DIV - 1));
  assign stage_tick[0] = (us_cnt_q == UW'(US_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xtal_cnt_q <= '0;
      us_cnt_q   <= '0;
    end else begin
      xtal_cnt_q <= xtal_tick ? '0 : xtal_cnt_q + XW'(1);
      us_cnt_q   <= stage_tick[0] ? '0 : us_cnt_q + UW'(1);
    end
  end

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_decade
    logic [DW-1:0] cnt_q;
    logic          wrap;
    assign wrap = (cnt_q == DW'(DECADE - 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (stage_tick[g]) cnt_q <= wrap ? '0 : cnt_q + DW'(1);
    end
    assign stage_tick[g+1] = stage_tick[g] && wrap;
  end

  always_comb begin
    unique case (sel_i)
      TB_XTAL:  tick_o = xtal_tick;
      TB_1US:   tick_o = stage_tick[0];
      TB_10US:  tick_o = stage_tick[1];
      TB_100US: tick_o = stage_tick[2];
      default:  tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lg_level_qual.sv
module lg_level_qual
  import lg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             tick_i,
  input  logic [DEL_W-1:0] delay_i,
  input  logic             bypass_i,
  output logic             level_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int unsigned MAX_CNT = ((2 ** DEL_W) - 1) * DEL_MULT;
  localparam int unsigned CW = $clog2(MAX_CNT + 1);

  logic [CW-1:0] cnt_q, target;
  logic          level_q, rise_q, fall_q, differ, accept;

  assign target = CW'(delay_i) * CW'(DEL_MULT);
  assign differ = (sync_i != level_q);
  assign accept = differ && (bypass_i || (tick_i && (cnt_q == target - CW'(1))));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      rise_q <= accept && sync_i;
      fall_q <= accept && !sync_i;
      if (accept) begin
        level_q <= sync_i;
        cnt_q   <= '0;
      end else if (!differ || bypass_i) begin
        cnt_q <= '0;  // reversion restarts qualification
      end else if (tick_i) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign level_o = level_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
endmodule

// File: rtl/line_deglitch.sv
module line_deglitch
  import lg_pkg::*;
#(
  parameter int unsigned XTAL_DIV  = 3,
  parameter int unsigned US_CYCLES = 24,
  parameter int unsigned DECADE    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic [SEL_W-1:0] tick_sel_i,
  input  logic [DEL_W-1:0] delay_i,
  input  logic             filt_en_i,
  output logic             line_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic sync_q, tick, bypass;

  assign bypass = !filt_en_i || (delay_i == '0);

  lg_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (sync_q)
  );

  lg_tick_gen #(
    .XTAL_DIV (XTAL_DIV),
    .US_CYCLES(US_CYCLES),
    .DECADE   (DECADE)
  ) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (tick_base_e'(tick_sel_i)),
    .tick_o(tick)
  );

  lg_level_qual u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_q),
    .tick_i  (tick),
    .delay_i (delay_i),
    .bypass_i(bypass),
    .level_o (line_o),
    .rise_o  (rise_o),
    .fall_o  (fall_o)
  );
endmodule

// File: rtl/lg_checker.sv
module lg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic line_o,
  input logic rise_o,
  input logic fall_o,
  input logic sync_i,
  input logic tick_i,
  input logic bypass_i
);
  assert_idle_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (line_o || !rst_ni));

  assert_rise_marks_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (line_o && !$past(line_o)));

  assert_fall_marks_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!line_o && $past(line_o)));

  assert_change_flagged_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> (rise_o || fall_o));

  assert_edges_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));

  assert_bypass_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bypass_i) |-> (line_o == $past(sync_i)));

  assert_change_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(bypass_i) && (line_o != $past(line_o))) |-> $past(tick_i));

  assert_change_to_input_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> (line_o == $past(sync_i)));
endmodule

bind line_deglitch lg_checker u_lg_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .line_o  (line_o),
  .rise_o  (rise_o),
  .fall_o  (fall_o),
  .sync_i  (sync_q),
  .tick_i  (tick),
  .bypass_i(bypass)
);

// File: tb/line_deglitch_tb_top.sv
module line_deglitch_tb_top;
  localparam int XD = 3, UC = 4, DC = 3;
  localparam int WATCHDOG = 190000;
  // {sel[1:0], delay[2:0], long}
  localparam logic [5:0] VEC [12] = '{
    {2'd1, 3'd7, 1'b0}, {2'd1, 3'd7, 1'b1}, {2'd0, 3'd1, 1'b0},
    {2'd0, 3'd1, 1'b1}, {2'd2, 3'd2, 1'b0}, {2'd2, 3'd2, 1'b1},
    {2'd3, 3'd1, 1'b1}, {2'd3, 3'd1, 1'b0}, {2'd1, 3'd3, 1'b1},
    {2'd0, 3'd7, 1'b1}, {2'd0, 3'd4, 1'b0}, {2'd3, 3'd2, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_i = 1'b1, filt_en = 1'b1;
  logic [1:0] sel = 2'd1;
  logic [2:0] del = 3'd7;
  logic line_o, rise_o, fall_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int n_rise = 0, n_fall = 0, t_rise = 0, t_fall = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  line_deglitch #(.XTAL_DIV(XD), .US_CYCLES(UC), .DECADE(DC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line_i), .tick_sel_i(sel),
    .delay_i(del), .filt_en_i(filt_en), .line_o(line_o),
    .rise_o(rise_o), .fall_o(fall_o)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n) begin
    if (rise_o) begin n_rise++; t_rise = cyc; end
    if (fall_o) begin n_fall++; t_fall = cyc; end
  end

  function automatic int period(input logic [1:0] s);
    case (s)
      2'd0: return XD;
      2'd1: return UC;
      2'd2: return UC * DC;
      default: return UC * DC * DC;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > WATCHDOG && !done) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
    finish_run();
  end

  initial begin
    int t0, f0, r0, p, n, len;
    wait_n(3);
    chk(line_o === 1'b1, "R1", line_o, 1);
    chk(rise_o === 1'b0 && fall_o === 1'b0, "R1", rise_o | fall_o, 0);
    rst_n = 1'b1;
    wait_n(5);
    chk(line_o === 1'b1 && n_rise == 0 && n_fall == 0, "R1", n_rise + n_fall, 0);

    // table-driven low pulses through the filter
    foreach (VEC[i]) begin
      sel = VEC[i][5:4]; del = VEC[i][3:1];
      p = period(sel); n = 3 * del;
      len = VEC[i][0] ? n * p + p + 4 : (n - 1) * p - 1;
      wait_n(4);
      f0 = n_fall; r0 = n_rise;
      line_i = 1'b0; t0 = cyc;
      wait_n(len);
      line_i = 1'b1;
      wait_n(n * p + 12);
      if (VEC[i][0]) begin
        chk(n_fall == f0 + 1, "R6", n_fall - f0, 1);
        chk(t_fall - t0 >= (n - 1) * p + 3 && t_fall - t0 <= n * p + 2,
            "R4 R9", t_fall - t0, n * p);
        chk(n_rise == r0 + 1, "R8", n_rise - r0, 1);
      end else begin
        chk(n_fall == f0 && n_rise == r0, "R5", n_fall - f0, 0);
      end
      chk(line_o === 1'b1, "R5 R6", line_o, 1);
    end

    // R5: high glitch while low is dropped
    sel = 2'd0; del = 3'd1;
    line_i = 1'b0; wait_n(20);
    chk(line_o === 1'b0, "R6", line_o, 0);
    r0 = n_rise;
    line_i = 1'b1; wait_n(5); line_i = 1'b0; wait_n(20);
    chk(n_rise == r0 && line_o === 1'b0, "R5", n_rise - r0, 0);
    line_i = 1'b1; wait_n(20);
    chk(line_o === 1'b1, "R6", line_o, 1);

    // R7: one-cycle return restarts the count
    sel = 2'd1; del = 3'd1; wait_n(4);
    f0 = n_fall;
    line_i = 1'b0; wait_n(7); line_i = 1'b1; wait_n(1);
    line_i = 1'b0; wait_n(7); line_i = 1'b1; wait_n(30);
    chk(n_fall == f0 && line_o === 1'b1, "R7", n_fall - f0, 0);

    // R3: enable low bypasses any delay
    filt_en = 1'b0; del = 3'd7; wait_n(4);
    line_i = 1'b0; t0 = cyc; wait_n(8);
    chk(t_fall - t0 == 3, "R3", t_fall - t0, 3);
    line_i = 1'b1; t0 = cyc; wait_n(8);
    chk(t_rise - t0 == 3, "R3", t_rise - t0, 3);

    // R2: delay 0 is transparent, single-cycle pulse passes
    filt_en = 1'b1; del = 3'd0; wait_n(4);
    f0 = n_fall; r0 = n_rise;
    line_i = 1'b0; t0 = cyc; wait_n(1); line_i = 1'b1; wait_n(8);
    chk(t_fall - t0 == 3, "R2", t_fall - t0, 3);
    chk(n_fall == f0 + 1 && n_rise == r0 + 1, "R2 R8", n_rise - r0, 1);
    chk(t_rise - t_fall == 1, "R2", t_rise - t_fall, 1);

    finish_run();
  end
endmodule